// File: doc/BRIEF.md
# Two-Way Processor Mailbox

This block lets two processor ports pass 32-bit words to each other through a pair of small queues that run in opposite directions. One queue runs from port 0 to port 1 and the other runs from port 1 to port 0. Each port can only write into the queue it sends on and can only read from the queue it receives on. Both ports share one clock.

Each port has a write strobe with a data word for its outgoing queue and a read strobe for its incoming queue. The read data is returned in the same cycle as the strobe. Each port also has a 4-bit status view and a strobe that clears the error flags in that view. The status view covers only that port's own pair of queues.

The status view shows four things:
- whether incoming data is waiting;
- whether the outgoing queue has room;
- whether the port has written into a full outgoing queue since the last clear;
- whether the port has read from an empty incoming queue since the last clear.

The interrupt output of a port is high whenever any of the data-waiting or error conditions in its view is set. Software can therefore either poll the status view or wait for the interrupt.

Top module: `xcore_mailbox`

## Requirements
- R1: Words written by port 0 are read by port 1, and words written by port 1 are read by port 0. Each direction delivers words in the order they were written and holds up to DEPTH (default 8) words.
- R2: A word written into an empty queue sets the reader's data-waiting bit, status bit 0, in the cycle after the write. The read strobe returns the oldest word combinationally.
- R3: Status bit 1 (room available) is 1 exactly when the port's outgoing queue holds fewer than DEPTH words.
- R4: A write to a full outgoing queue discards the word and leaves the stored words unchanged. It also sets the sticky write-error bit, status bit 2, in the next cycle.
- R5: A read from an empty incoming queue returns zero and leaves the pointers unchanged. It also sets the sticky read-error bit, status bit 3, in the next cycle.
- R6: Bits 2 and 3 stay set until the port pulses its clear strobe. If a new error occurs in the same cycle as the clear, the error wins. The clear strobe has no effect on bits 0 and 1.
- R7: A port's interrupt equals the OR of its status bits 0, 2 and 3.
- R8: A write and a read on the same queue in the same cycle are both carried out when the queue is neither full nor empty, and the word count is unchanged.
- R9: After reset both queues are empty. Both status views read 4'b0010, both interrupts are low and both read-data outputs are zero.
- R10: Each status view reflects only its own port's incoming and outgoing queues. An error or a write by one port does not change the other port's room or error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p0_tx_wr | input | 1 | Port 0 write strobe for the 0-to-1 queue |
| p0_tx_data | input | DATA_W | Port 0 word to send |
| p0_rx_rd | input | 1 | Port 0 read strobe for the 1-to-0 queue |
| p0_rx_data | output | DATA_W | Oldest 1-to-0 word during a read, otherwise zero |
| p0_st_clr | input | 1 | Port 0 strobe that clears its error bits |
| p0_status | output | 4 | Port 0 status: bit0 data waiting, bit1 room, bit2 write error, bit3 read error |
| p0_irq | output | 1 | Port 0 interrupt |
| p1_tx_wr | input | 1 | Port 1 write strobe for the 1-to-0 queue |
| p1_tx_data | input | DATA_W | Port 1 word to send |
| p1_rx_rd | input | 1 | Port 1 read strobe for the 0-to-1 queue |
| p1_rx_data | output | DATA_W | Oldest 0-to-1 word during a read, otherwise zero |
| p1_st_clr | input | 1 | Port 1 strobe that clears its error bits |
| p1_status | output | 4 | Port 1 status, same layout as port 0 |
| p1_irq | output | 1 | Port 1 interrupt |

## Verification
The hardest state to reach from the ports is a write into a full queue. It needs DEPTH accepted writes with no reads in between. The stimulus then must confirm that the rejected word never appears, which it does by draining all DEPTH words and checking each one.

A clear that lands in the same cycle as a new error is equally narrow. The bench reaches it by issuing an empty read and a clear strobe on the same edge. It then checks that the read-error bit survives.

A write and a read on the same queue in the same cycle is reached by preloading one word and then issuing both strobes on the same edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ST_W   = 4;
  localparam int ST_VLD = 0;  // incoming word waiting
  localparam int ST_RDY = 1;  // outgoing queue has room
  localparam int ST_WOF = 2;  // sticky: write into full queue
  localparam int ST_ROE = 3;  // sticky: read from empty queue

  function automatic logic [ST_W-1:0] pack_status(input logic vld, input logic rdy,
                                                  input logic wof, input logic roe);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_VLD] = vld;
    s[ST_RDY] = rdy;
    s[ST_WOF] = wof;
    s[ST_ROE] = roe;
    return s;
  endfunction

  function automatic logic irq_of(input logic [ST_W-1:0] s);
    return s[ST_VLD] | s[ST_WOF] | s[ST_ROE];
  endfunction

  function automatic int wrap_inc(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  function automatic int occ_next(input int occ, input logic push, input logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              ovf_evt,
  output logic              udf_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push_req & ~full;
  assign ovf_evt = push_req & full;
  assign pop_ok  = pop_req & ~empty;
  assign udf_evt = pop_req & empty;

  assign pop_data = pop_ok ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(wrap_inc(int'(rd_ptr), DEPTH));
      count <= CNT_W'(occ_next(int'(count), push_ok, pop_ok));
    end
  end
endmodule

// File: rtl/mbx_port_status.sv
module mbx_port_status
  import mbx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_empty,
  input  logic            tx_full,
  input  logic            ovf_evt,
  input  logic            udf_evt,
  input  logic            st_clr,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic wof_q, roe_q;

  // a new event takes priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wof_q <= 1'b0;
      roe_q <= 1'b0;
    end else begin
      wof_q <= ovf_evt | (wof_q & ~st_clr);
      roe_q <= udf_evt | (roe_q & ~st_clr);
    end
  end

  assign status = pack_status(~rx_empty, ~tx_full, wof_q, roe_q);
  assign irq    = irq_of(status);
endmodule

// File: rtl/xcore_mailbox.sv
module xcore_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_tx_wr,
  input  logic [DATA_W-1:0] p0_tx_data,
  input  logic              p0_rx_rd,
  output logic [DATA_W-1:0] p0_rx_data,
  input  logic              p0_st_clr,
  output logic [3:0]        p0_status,
  output logic              p0_irq,
  input  logic              p1_tx_wr,
  input  logic [DATA_W-1:0] p1_tx_data,
  input  logic              p1_rx_rd,
  output logic [DATA_W-1:0] p1_rx_data,
  input  logic              p1_st_clr,
  output logic [3:0]        p1_status,
  output logic              p1_irq
);
  localparam int NP    = 2;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // per-port views, index = port number
  logic [NP-1:0]             tx_wr, rx_rd, st_clr, irq_v;
  logic [NP-1:0][DATA_W-1:0] tx_data, rx_data;
  logic [NP-1:0][ST_W-1:0]   status;

  // per-queue signals, index = writing port
  logic [NP-1:0][CNT_W-1:0]  f_count;
  logic [NP-1:0][DATA_W-1:0] f_pop_data;
  logic [NP-1:0]             f_empty, f_full, f_push_ok, f_pop_ok, f_ovf, f_udf;

  assign tx_wr   = {p1_tx_wr, p0_tx_wr};
  assign rx_rd   = {p1_rx_rd, p0_rx_rd};
  assign st_clr  = {p1_st_clr, p0_st_clr};
  assign tx_data = {p1_tx_data, p0_tx_data};

  assign p0_rx_data = rx_data[0];
  assign p1_rx_data = rx_data[1];
  assign p0_status  = status[0];
  assign p1_status  = status[1];
  assign p0_irq     = irq_v[0];
  assign p1_irq     = irq_v[1];

  for (genvar g = 0; g < NP; g++) begin : g_lane
    // queue g: written by port g, read by the other port
    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (tx_wr[g]),
      .push_data(tx_data[g]),
      .pop_req  (rx_rd[NP-1-g]),
      .pop_data (f_pop_data[g]),
      .count    (f_count[g]),
      .empty    (f_empty[g]),
      .full     (f_full[g]),
      .push_ok  (f_push_ok[g]),
      .pop_ok   (f_pop_ok[g]),
      .ovf_evt  (f_ovf[g]),
      .udf_evt  (f_udf[g])
    );

    // port g: outgoing queue g, incoming queue NP-1-g
    assign rx_data[g] = f_pop_data[NP-1-g];

    mbx_port_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_empty(f_empty[NP-1-g]),
      .tx_full (f_full[g]),
      .ovf_evt (f_ovf[g]),
      .udf_evt (f_udf[NP-1-g]),
      .st_clr  (st_clr[g]),
      .status  (status[g]),
      .irq     (irq_v[g])
    );
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0][CNT_W-1:0] f_count,
  input logic [1:0]            f_push_ok,
  input logic [1:0]            f_pop_ok,
  input logic [1:0]            f_ovf,
  input logic [1:0]            f_udf,
  input logic [1:0][ST_W-1:0]  status,
  input logic [1:0]            irq,
  input logic [1:0]            st_clr,
  input logic [1:0][DATA_W-1:0] rx_data
);
  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      f_count[g] <= CNT_W'(DEPTH));

    p_visible_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      f_push_ok[g] |=> status[1-g][ST_VLD]);

    p_no_room_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (f_count[g] == CNT_W'(DEPTH)) |-> !status[g][ST_RDY]);

    p_drop_on_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (f_ovf[g] && !f_pop_ok[g]) |=> (f_count[g] == $past(f_count[g])) && status[g][ST_WOF]);

    p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      f_udf[g] |-> (rx_data[1-g] == '0));

    p_roe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      f_udf[g] |=> status[1-g][ST_ROE]);

    p_wof_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status[g][ST_WOF] && !st_clr[g]) |=> status[g][ST_WOF]);

    p_roe_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status[g][ST_ROE] && !st_clr[g]) |=> status[g][ST_ROE]);

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> (status[g][ST_VLD] || status[g][ST_WOF] || status[g][ST_ROE]));

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq[g] |-> (status[g][ST_VLD] == 1'b0 && status[g][ST_WOF] == 1'b0 && status[g][ST_ROE] == 1'b0));

    p_both_ops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (f_push_ok[g] && f_pop_ok[g]) |=> $stable(f_count[g]));
  end
endmodule

bind xcore_mailbox mbx_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_mbx_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .f_count  (f_count),
  .f_push_ok(f_push_ok),
  .f_pop_ok (f_pop_ok),
  .f_ovf    (f_ovf),
  .f_udf    (f_udf),
  .status   (status),
  .irq      (irq_v),
  .st_clr   (st_clr),
  .rx_data  (rx_data)
);

// File: tb/xcore_mailbox_bench.sv
module xcore_mailbox_bench;
  localparam int DW    = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p0_tx_wr = 0, p0_rx_rd = 0, p0_st_clr = 0;
  logic p1_tx_wr = 0, p1_rx_rd = 0, p1_st_clr = 0;
  logic [DW-1:0] p0_tx_data = '0, p1_tx_data = '0;
  logic [DW-1:0] p0_rx_data, p1_rx_data;
  logic [3:0] p0_status, p1_status;
  logic p0_irq, p1_irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  xcore_mailbox #(.DATA_W(DW), .DEPTH(DEPTH)) u_xcore_mailbox (
    .clk(clk), .rst_n(rst_n),
    .p0_tx_wr(p0_tx_wr), .p0_tx_data(p0_tx_data), .p0_rx_rd(p0_rx_rd),
    .p0_rx_data(p0_rx_data), .p0_st_clr(p0_st_clr), .p0_status(p0_status), .p0_irq(p0_irq),
    .p1_tx_wr(p1_tx_wr), .p1_tx_data(p1_tx_data), .p1_rx_rd(p1_rx_rd),
    .p1_rx_data(p1_rx_data), .p1_st_clr(p1_st_clr), .p1_status(p1_status), .p1_irq(p1_irq)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] st(input int p);
    return (p == 0) ? p0_status : p1_status;
  endfunction

  function automatic logic irq(input int p);
    return (p == 0) ? p0_irq : p1_irq;
  endfunction

  // every task starts and ends just after a falling edge
  task automatic push(input int p, input logic [DW-1:0] d);
    if (p == 0) begin p0_tx_wr = 1; p0_tx_data = d; end
    else        begin p1_tx_wr = 1; p1_tx_data = d; end
    @(negedge clk);
    p0_tx_wr = 0; p1_tx_wr = 0;
  endtask

  task automatic pop(input int p, input logic [DW-1:0] exp, input string req);
    if (p == 0) p0_rx_rd = 1; else p1_rx_rd = 1;
    #1;
    chk(req, "read data", (p == 0) ? p0_rx_data : p1_rx_data, exp);
    @(negedge clk);
    p0_rx_rd = 0; p1_rx_rd = 0;
  endtask

  task automatic clr(input int p);
    if (p == 0) p0_st_clr = 1; else p1_st_clr = 1;
    @(negedge clk);
    p0_st_clr = 0; p1_st_clr = 0;
  endtask

  task automatic t_reset;
    chk("R9", "p0 status", 32'(p0_status), 32'h2);
    chk("R9", "p1 status", 32'(p1_status), 32'h2);
    chk("R9", "irqs", 32'({p1_irq, p0_irq}), 32'h0);
    chk("R9", "rx data", p0_rx_data | p1_rx_data, 32'h0);
  endtask

  task automatic t_visible;
    push(0, 32'h0000_00A5);
    chk("R2", "p1 status after write", 32'(st(1)), 32'h3);
    chk("R7", "p1 irq on data", 32'(irq(1)), 32'h1);
    chk("R10", "p0 status untouched", 32'(st(0)), 32'h2);
    pop(1, 32'h0000_00A5, "R1");
    chk("R2", "p1 status drained", 32'(st(1)), 32'h2);
    chk("R7", "p1 irq drained", 32'(irq(1)), 32'h0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 3; i++) push(1, 32'hBEEF_0000 + 32'(i));
    chk("R1", "p0 sees data", 32'(st(0)), 32'h3);
    for (int i = 0; i < 3; i++) pop(0, 32'hBEEF_0000 + 32'(i), "R1");
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) push(0, 32'h1000 + 32'(i));
    chk("R3", "p0 room bit clear when full", 32'(st(0)), 32'h0);
    push(0, 32'hDEAD_DEAD);
    chk("R4", "p0 write error set", 32'(st(0)), 32'h4);
    chk("R7", "p0 irq on write error", 32'(irq(0)), 32'h1);
    chk("R10", "p1 error bits clean", 32'(st(1) & 4'hC), 32'h0);
    for (int i = 0; i < DEPTH; i++) pop(1, 32'h1000 + 32'(i), "R4");
    chk("R4", "p1 empty after drain, dropped word gone", 32'(st(1)), 32'h2);
    repeat (3) @(negedge clk);
    chk("R6", "write error still set", 32'(st(0)), 32'h6);
    clr(0);
    chk("R6", "clear drops error", 32'(st(0)), 32'h2);
    chk("R7", "p0 irq low after clear", 32'(irq(0)), 32'h0);
  endtask

  task automatic t_underflow;
    pop(1, 32'h0, "R5");
    chk("R5", "p1 read error set", 32'(st(1)), 32'hA);
    chk("R7", "p1 irq on read error", 32'(irq(1)), 32'h1);
    push(0, 32'h0000_0077);
    pop(1, 32'h0000_0077, "R5");
    clr(1);
    chk("R6", "p1 read error cleared", 32'(st(1)), 32'h2);
    // clear and a new empty read on the same edge: the error wins
    p1_st_clr = 1; p1_rx_rd = 1;
    @(negedge clk);
    p1_st_clr = 0; p1_rx_rd = 0;
    chk("R6", "error wins over clear", 32'(st(1)), 32'hA);
    clr(1);
  endtask

  task automatic t_clear_keeps_live;
    push(1, 32'h0000_0042);
    clr(0);
    chk("R6", "clear keeps data-waiting bit", 32'(st(0)), 32'h3);
    pop(0, 32'h0000_0042, "R6");
  endtask

  task automatic t_simul;
    push(0, 32'hCAFE_0001);
    p0_tx_wr = 1; p0_tx_data = 32'hCAFE_0002; p1_rx_rd = 1;
    #1;
    chk("R8", "read during write", p1_rx_data, 32'hCAFE_0001);
    @(negedge clk);
    p0_tx_wr = 0; p1_rx_rd = 0;
    chk("R8", "one word left", 32'(st(1)), 32'h3);
    pop(1, 32'hCAFE_0002, "R8");
    chk("R8", "queue empty", 32'(st(1)), 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_visible();
    t_order();
    t_full();
    t_underflow();
    t_clear_keeps_live();
    t_simul();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule